// File: doc/BRIEF.md
# Hardware Breakpoint Trigger Register Bank

This block holds the machine-mode register state of a small breakpoint unit with two address/data-match triggers. The CSR port reaches four registers. The first is a trigger-select register. The second is a control register for the selected trigger. The third is a compare-value register for the selected trigger. The fourth is a third data register, which does not exist and is always reported as unavailable. A single `csr_sel_i` code chooses the register. Reads are combinational, and writes take effect at the next rising clock edge.

Control writes pass through a field-by-field legalizer before they are stored. The trigger kind always reads as address-match (2). The debug-mode bit and every unimplemented feature field read zero. An access-size code that the unit cannot match collapses to "any size" and is not stored. The legalized control word and the compare value of every trigger are driven out continuously to the downstream matching logic.

The data-path width is set by `XLEN` (32 or 64). With XLEN 64, the size field gains two upper bits.

Top module: `dbg_trig_csr_bank`

## Requirements
- R1: The trigger-select register (`csr_sel_i` = 0) stores all XLEN bits written to it and reads back exactly that value.
- R2: `csr_avail_o` is 1 for `csr_sel_i` = 0. It is 1 for `csr_sel_i` = 1 (control) or 2 (compare) only while the select value is below 2. It is always 0 for `csr_sel_i` = 3 (third data register).
- R3: While `csr_avail_o` is 0, `csr_rdata_o` is zero and a write changes no trigger register.
- R4: The kind field of each control word (bits XLEN-1:XLEN-4) always reads 2, whatever value is written.
- R5: The debug-mode bit (XLEN-5) and bit 5 always read zero. Only the kind field, the size bits and bits 6, 4:0 can be nonzero.
- R6: The size code is taken from bits 17:16 as its low half. With XLEN 64, bits 22:21 form its high half, giving a 4-bit code. With XLEN 32 the high half is always 0 and bits 22:21 read zero.
- R7: Size codes 0, 1, 2, 3 and 5 are stored as written. Any other code leaves both size halves at zero.
- R8: Bits 0 (load), 1 (store), 2 (execute), 3 (U), 4 (S) and 6 (M) of a control write are stored as written.
- R9: After reset, the select register is 0, each control word holds only kind 2, and each compare value is zero.
- R10: The compare-value register of the selected trigger stores all XLEN bits written and reads them back.
- R11: `trig_ctrl_o` and `trig_cmp_o` carry trigger i's control word and compare value in bits [i*XLEN +: XLEN].
- R12: A control or compare write changes only the trigger named by the select register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| csr_sel_i | input | 2 | Register code: 0 select, 1 control, 2 compare, 3 third data |
| csr_we_i | input | 1 | Write strobe |
| csr_wdata_i | input | XLEN | Write data |
| csr_rdata_o | output | XLEN | Read data, combinational |
| csr_avail_o | output | 1 | Addressed register exists for the current select value |
| trig_ctrl_o | output | 2*XLEN | Legalized control words of all triggers |
| trig_cmp_o | output | 2*XLEN | Compare values of all triggers |

## Verification
The assertions assume that the port inputs are known and settled at every rising edge. They also assume that `csr_sel_i` may change in every cycle without a handshake. The write-ignored property assumes that the select register can only be changed by a write coded 0, which then leaves all trigger registers alone.

The bench drives all inputs on the falling edge, so inputs are stable when the registers capture them. It sweeps every size code, every value of the seven low bits, and select values in range, at the boundary and far above it. All of this runs on a 32-bit instance and a 64-bit instance that share the same stimulus.

// File: rtl/dbg_trig_pkg.sv
package dbg_trig_pkg;

  typedef enum logic [1:0] {
    CSR_TSEL  = 2'd0,
    CSR_CTRL  = 2'd1,
    CSR_CMP   = 2'd2,
    CSR_DATA3 = 2'd3
  } csr_sel_e;

  localparam logic [3:0] KIND_ADDR_MATCH = 4'd2;

  localparam int unsigned BIT_LOAD   = 0;
  localparam int unsigned BIT_STORE  = 1;
  localparam int unsigned BIT_EXEC   = 2;
  localparam int unsigned BIT_PRIV_U = 3;
  localparam int unsigned BIT_PRIV_S = 4;
  localparam int unsigned BIT_PRIV_M = 6;
  localparam int unsigned SIZELO_LSB = 16;
  localparam int unsigned SIZEHI_LSB = 21;

  // 4: six bytes, 6..15: reserved
  function automatic logic size_code_ok(input logic [3:0] code);
    case (code)
      4'd0, 4'd1, 4'd2, 4'd3, 4'd5: size_code_ok = 1'b1;
      default:                      size_code_ok = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/dbg_trig_legalize.sv
module dbg_trig_legalize
  import dbg_trig_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] wdata_i,
  output logic [XLEN-1:0] ctrl_o
);

  localparam bit HAS_SIZEHI = (XLEN == 64);

  logic [1:0] sizelo;
  logic [1:0] sizehi;
  logic [3:0] code;
  logic       size_keep;

  assign sizelo = wdata_i[SIZELO_LSB +: 2];

  generate
    if (HAS_SIZEHI) begin : g_hi
      assign sizehi = wdata_i[SIZEHI_LSB +: 2];
    end else begin : g_no_hi
      assign sizehi = 2'b00;
    end
  endgenerate

  assign code      = {sizehi, sizelo};
  assign size_keep = size_code_ok(code);

  always_comb begin
    ctrl_o = '0;
    ctrl_o[XLEN-1 -: 4]  = KIND_ADDR_MATCH;
    ctrl_o[BIT_LOAD]     = wdata_i[BIT_LOAD];
    ctrl_o[BIT_STORE]    = wdata_i[BIT_STORE];
    ctrl_o[BIT_EXEC]     = wdata_i[BIT_EXEC];
    ctrl_o[BIT_PRIV_U]   = wdata_i[BIT_PRIV_U];
    ctrl_o[BIT_PRIV_S]   = wdata_i[BIT_PRIV_S];
    ctrl_o[BIT_PRIV_M]   = wdata_i[BIT_PRIV_M];
    if (size_keep) begin
      ctrl_o[SIZELO_LSB +: 2] = sizelo;
      if (HAS_SIZEHI) ctrl_o[SIZEHI_LSB +: 2] = sizehi;
    end
  end

endmodule

// File: rtl/dbg_trig_slot.sv
module dbg_trig_slot
  import dbg_trig_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ctrl_we_i,
  input  logic            cmp_we_i,
  input  logic [XLEN-1:0] ctrl_wdata_i,
  input  logic [XLEN-1:0] cmp_wdata_i,
  output logic [XLEN-1:0] ctrl_o,
  output logic [XLEN-1:0] cmp_o
);

  localparam logic [XLEN-1:0] CTRL_RST = {KIND_ADDR_MATCH, {(XLEN-4){1'b0}}};

  logic [XLEN-1:0] ctrl_q;
  logic [XLEN-1:0] cmp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= CTRL_RST;
    end else if (ctrl_we_i) begin
      ctrl_q <= ctrl_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_q <= '0;
    end else if (cmp_we_i) begin
      cmp_q <= cmp_wdata_i;
    end
  end

  assign ctrl_o = ctrl_q;
  assign cmp_o  = cmp_q;

endmodule

// File: rtl/dbg_trig_csr_bank.sv
module dbg_trig_csr_bank
  import dbg_trig_pkg::*;
#(
  parameter int unsigned XLEN     = 32,
  parameter int unsigned NUM_TRIG = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [1:0]               csr_sel_i,
  input  logic                     csr_we_i,
  input  logic [XLEN-1:0]          csr_wdata_i,
  output logic [XLEN-1:0]          csr_rdata_o,
  output logic                     csr_avail_o,
  output logic [NUM_TRIG*XLEN-1:0] trig_ctrl_o,
  output logic [NUM_TRIG*XLEN-1:0] trig_cmp_o
);

  localparam int unsigned IDX_W = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1;

  csr_sel_e        sel;
  logic [XLEN-1:0] tsel_q;
  logic            in_range;
  logic [IDX_W-1:0] idx;
  logic [XLEN-1:0] legal_ctrl;
  logic            wr_ok;
  logic [XLEN-1:0] ctrl_arr [NUM_TRIG];
  logic [XLEN-1:0] cmp_arr  [NUM_TRIG];
  logic [XLEN-1:0] ctrl_sel;
  logic [XLEN-1:0] cmp_sel;

  assign sel      = csr_sel_e'(csr_sel_i);
  assign in_range = (tsel_q < XLEN'(NUM_TRIG));
  assign idx      = tsel_q[IDX_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tsel_q <= '0;
    end else if (csr_we_i && sel == CSR_TSEL) begin
      tsel_q <= csr_wdata_i;
    end
  end

  always_comb begin
    case (sel)
      CSR_TSEL:          csr_avail_o = 1'b1;
      CSR_CTRL, CSR_CMP: csr_avail_o = in_range;
      default:           csr_avail_o = 1'b0;
    endcase
  end

  assign wr_ok = csr_we_i && csr_avail_o;

  dbg_trig_legalize #(.XLEN(XLEN)) u_legal (
    .wdata_i (csr_wdata_i),
    .ctrl_o  (legal_ctrl)
  );

  for (genvar i = 0; i < NUM_TRIG; i++) begin : g_slot
    logic hit;
    assign hit = (idx == IDX_W'(i));

    dbg_trig_slot #(.XLEN(XLEN)) u_slot (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .ctrl_we_i    (wr_ok && hit && sel == CSR_CTRL),
      .cmp_we_i     (wr_ok && hit && sel == CSR_CMP),
      .ctrl_wdata_i (legal_ctrl),
      .cmp_wdata_i  (csr_wdata_i),
      .ctrl_o       (ctrl_arr[i]),
      .cmp_o        (cmp_arr[i])
    );

    assign trig_ctrl_o[i*XLEN +: XLEN] = ctrl_arr[i];
    assign trig_cmp_o[i*XLEN +: XLEN]  = cmp_arr[i];
  end

  always_comb begin
    ctrl_sel = '0;
    cmp_sel  = '0;
    for (int k = 0; k < NUM_TRIG; k++) begin
      if (idx == IDX_W'(k)) begin
        ctrl_sel = ctrl_arr[k];
        cmp_sel  = cmp_arr[k];
      end
    end
  end

  always_comb begin
    csr_rdata_o = '0;
    if (csr_avail_o) begin
      case (sel)
        CSR_TSEL: csr_rdata_o = tsel_q;
        CSR_CTRL: csr_rdata_o = ctrl_sel;
        CSR_CMP:  csr_rdata_o = cmp_sel;
        default:  csr_rdata_o = '0;
      endcase
    end
  end

endmodule

// File: rtl/dbg_trig_csr_chk.sv
module dbg_trig_csr_chk
  import dbg_trig_pkg::*;
#(
  parameter int unsigned XLEN     = 32,
  parameter int unsigned NUM_TRIG = 2
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic [1:0]               csr_sel_i,
  input logic                     csr_we_i,
  input logic [XLEN-1:0]          csr_wdata_i,
  input logic [XLEN-1:0]          csr_rdata_o,
  input logic                     csr_avail_o,
  input logic [NUM_TRIG*XLEN-1:0] trig_ctrl_o,
  input logic [NUM_TRIG*XLEN-1:0] trig_cmp_o
);

  // R2
  third_unavail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_sel_i == 2'd3) |-> !csr_avail_o);

  // R2
  tsel_avail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_sel_i == 2'd0) |-> csr_avail_o);

  // R3
  unavail_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !csr_avail_o |-> (csr_rdata_o == '0));

  // R3
  unavail_write_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_we_i && !csr_avail_o) |=> ($stable(trig_ctrl_o) && $stable(trig_cmp_o)));

  // R1
  tsel_readback_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_we_i && csr_sel_i == 2'd0) |=>
      ((csr_sel_i != 2'd0) || (csr_rdata_o == $past(csr_wdata_i))));

  for (genvar i = 0; i < NUM_TRIG; i++) begin : g_trig
    logic [XLEN-1:0] c;
    logic [3:0]      code;
    assign c    = trig_ctrl_o[i*XLEN +: XLEN];
    assign code = (XLEN == 64) ? {c[SIZEHI_LSB +: 2], c[SIZELO_LSB +: 2]}
                               : {2'b00, c[SIZELO_LSB +: 2]};

    // R4
    kind_fixed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      c[XLEN-1 -: 4] == KIND_ADDR_MATCH);

    // R5
    zero_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (c[XLEN-5] == 1'b0) && (c[5] == 1'b0));

    // R7
    size_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      size_code_ok(code));

    // R6
    sizehi_narrow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (XLEN != 64) |-> (c[SIZEHI_LSB +: 2] == 2'b00));
  end

endmodule

bind dbg_trig_csr_bank dbg_trig_csr_chk #(.XLEN(XLEN), .NUM_TRIG(NUM_TRIG)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .csr_sel_i   (csr_sel_i),
  .csr_we_i    (csr_we_i),
  .csr_wdata_i (csr_wdata_i),
  .csr_rdata_o (csr_rdata_o),
  .csr_avail_o (csr_avail_o),
  .trig_ctrl_o (trig_ctrl_o),
  .trig_cmp_o  (trig_cmp_o)
);

// File: tb/tb_dbg_trig_csr_bank.sv
`timescale 1ns/1ps
module tb_dbg_trig_csr_bank;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  sel = 2'd0;
  logic        we = 1'b0;
  logic [63:0] wd = '0;

  logic [31:0]  rd_n;
  logic [63:0]  rd_w;
  logic         av_n, av_w;
  logic [63:0]  ctrl_n, cmp_n;
  logic [127:0] ctrl_w, cmp_w;

  int checks = 0;
  int errors = 0;

  // model state
  logic [63:0] m_tsel;
  logic [63:0] m_ctrl_n [2];
  logic [63:0] m_ctrl_w [2];
  logic [63:0] m_cmp_n  [2];
  logic [63:0] m_cmp_w  [2];

  always #4 clk = ~clk;

  dbg_trig_csr_bank #(.XLEN(32)) dut (
    .clk_i(clk), .rst_ni(rst_n), .csr_sel_i(sel), .csr_we_i(we),
    .csr_wdata_i(wd[31:0]), .csr_rdata_o(rd_n), .csr_avail_o(av_n),
    .trig_ctrl_o(ctrl_n), .trig_cmp_o(cmp_n)
  );

  dbg_trig_csr_bank #(.XLEN(64)) dut_w (
    .clk_i(clk), .rst_ni(rst_n), .csr_sel_i(sel), .csr_we_i(we),
    .csr_wdata_i(wd), .csr_rdata_o(rd_w), .csr_avail_o(av_w),
    .trig_ctrl_o(ctrl_w), .trig_cmp_o(cmp_w)
  );

  function automatic logic [63:0] exp_ctrl(input logic [63:0] w, input bit wide);
    logic [3:0]  code;
    logic [63:0] e;
    code = wide ? {w[22:21], w[17:16]} : {2'b00, w[17:16]};
    e = w & 64'h5F;
    if (code inside {4'd0, 4'd1, 4'd2, 4'd3, 4'd5})
      e |= w & (wide ? 64'h0063_0000 : 64'h0003_0000);
    e |= wide ? (64'd2 << 60) : (64'd2 << 28);
    return e;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [63:0] d);
    bit ok;
    int t;
    @(negedge clk);
    sel = s; we = 1'b1; wd = d;
    ok = (s == 2'd0) || ((s != 2'd3) && (m_tsel < 64'd2));
    t  = int'(m_tsel[0]);
    @(negedge clk);
    we = 1'b0;
    if (ok) begin
      case (s)
        2'd0: m_tsel = d;
        2'd1: begin m_ctrl_n[t] = exp_ctrl(d, 1'b0); m_ctrl_w[t] = exp_ctrl(d, 1'b1); end
        2'd2: begin m_cmp_n[t] = {32'd0, d[31:0]}; m_cmp_w[t] = d; end
        default: ;
      endcase
    end
  endtask

  // R11 R12: all exported words against the model
  task automatic chk_ports(input string req);
    for (int i = 0; i < 2; i++) begin
      chk({req, " ctrl32"}, {32'd0, ctrl_n[i*32 +: 32]}, m_ctrl_n[i]);
      chk({req, " cmp32"},  {32'd0, cmp_n[i*32 +: 32]},  m_cmp_n[i]);
      chk({req, " ctrl64"}, ctrl_w[i*64 +: 64], m_ctrl_w[i]);
      chk({req, " cmp64"},  cmp_w[i*64 +: 64],  m_cmp_w[i]);
    end
  endtask

  task automatic rd(input string req, input logic [1:0] s,
                    input logic [63:0] exp_n, input logic [63:0] exp_w, input bit exp_av);
    sel = s; we = 1'b0;
    #1;
    chk({req, " rdata32"}, {32'd0, rd_n}, exp_n);
    chk({req, " rdata64"}, rd_w, exp_w);
    chk({req, " avail32"}, {63'd0, av_n}, {63'd0, exp_av});
    chk({req, " avail64"}, {63'd0, av_w}, {63'd0, exp_av});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    m_tsel = '0;
    for (int i = 0; i < 2; i++) begin
      m_ctrl_n[i] = 64'd2 << 28; m_ctrl_w[i] = 64'd2 << 60;
      m_cmp_n[i] = '0; m_cmp_w[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 reset state
    rd("R9 tsel", 2'd0, 0, 0, 1'b1);
    rd("R9 ctrl", 2'd1, 64'h2000_0000, 64'h2000_0000_0000_0000, 1'b1);
    rd("R9 cmp",  2'd2, 0, 0, 1'b1);
    chk_ports("R9");

    // R2 R3 third data register
    wr(2'd3, '1);
    rd("R2 third", 2'd3, 0, 0, 1'b0);
    chk_ports("R3 third write");

    // R1 select readback
    wr(2'd0, 64'h1234_5678_9ABC_DEF0);
    rd("R1 tsel", 2'd0, 64'h9ABC_DEF0, 64'h1234_5678_9ABC_DEF0, 1'b1);
    rd("R2 big ctrl", 2'd1, 0, 0, 1'b0);
    rd("R2 big cmp", 2'd2, 0, 0, 1'b0);
    // R3 writes ignored while out of range
    wr(2'd1, '1);
    wr(2'd2, 64'hDEAD_BEEF_CAFE_F00D);
    chk_ports("R3 ignored");

    // R2 boundary values of select
    for (int v = 0; v < 4; v++) begin
      wr(2'd0, 64'(v));
      rd("R2 tsel", 2'd0, 64'(v), 64'(v), 1'b1);
      rd("R2 ctrl avail", 2'd1, (v < 2) ? m_ctrl_n[v % 2] : 64'd0,
         (v < 2) ? m_ctrl_w[v % 2] : 64'd0, v < 2);
      rd("R2 third", 2'd3, 0, 0, 1'b0);
    end

    // R6 R7 size codes, both triggers
    for (int t = 0; t < 2; t++) begin
      wr(2'd0, 64'(t));
      for (int code = 0; code < 16; code++) begin
        logic [63:0] w;
        w = 64'hA5A5_5A5A_C3C3_3C3C ^ (64'(code) * 64'h0101_0101_0101_0101);
        w[22:21] = code[3:2];
        w[17:16] = code[1:0];
        wr(2'd1, w);
        rd("R6 R7 size", 2'd1, exp_ctrl(w, 1'b0), exp_ctrl(w, 1'b1), 1'b1);
        chk_ports("R12 size");
      end
    end

    // R4 R5 R8 low bit sweep on trigger 0
    wr(2'd0, 64'd0);
    for (int v = 0; v < 128; v++) begin
      logic [63:0] w;
      w = 64'(v) | 64'hF800_0000_F800_0000;
      wr(2'd1, w);
      rd("R4 R5 R8 bits", 2'd1, exp_ctrl(w, 1'b0), exp_ctrl(w, 1'b1), 1'b1);
    end
    wr(2'd1, '1);
    rd("R5 all ones", 2'd1, 64'h2003_005F, 64'h2000_0000_0000_005F, 1'b1);

    // R10 R11 R12 compare values
    for (int t = 0; t < 2; t++) begin
      logic [63:0] d;
      d = 64'h0F1E_2D3C_4B5A_6978 + 64'(t) * 64'h1111_1111_1111_1111;
      wr(2'd0, 64'(t));
      wr(2'd2, d);
      rd("R10 cmp", 2'd2, {32'd0, d[31:0]}, d, 1'b1);
      chk_ports("R11 R12 cmp");
    end
    wr(2'd0, 64'd0);
    rd("R12 cmp0 kept", 2'd2, m_cmp_n[0], m_cmp_w[0], 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule